// File: doc/BRIEF.md
# Press-Once Serial Byte Sender

This block sends one asynchronous serial character on a single output line each time an operator presses a push button. The button arrives raw and active low. Inside the block it is brought into the system clock domain, filtered against contact bounce, and then offered as a send request to a framing state machine. The byte to send is taken from a parallel input at the moment a frame begins.

The framing machine emits a low start bit, the data bits least significant first, and a high stop bit. Each bit lasts a fixed number of system clocks. After the stop bit the machine parks in a wind-down state. It raises a one-clock completion pulse and drops its busy flag there. It goes back to waiting only once the filtered request has gone away. A button held for any length of time therefore yields a single character. Every register in the block, including the edge and level detection for the button, runs on the one system clock.

Top module: `btn_uart_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txLine` is high, `txActive` is low and `txDone` is low.
- R2: A frame is one start bit at 0, then DATA_BITS data bits with bit 0 of the byte first, then one stop bit at 1. Every bit holds for CLKS_PER_BIT clocks.
- R3: `btnN` is active low. It passes through a two-stage synchronizer and a debouncer. When it goes low cleanly, `txLine` falls at the (DEBOUNCE_CLKS+3)-th rising clock edge after the change.
- R4: A low pulse on `btnN` shorter than DEBOUNCE_CLKS clocks starts no frame. A high pulse of that length while the button is held is not taken as a release.
- R5: Exactly one frame is sent per press, whether the button is held for less than a frame time or for much longer.
- R6: `txActive` is high from the first clock of the start bit through the last clock of the stop bit, and low at every other time.
- R7: `txDone` is high for exactly one clock, in the cycle after the last stop-bit clock, once per frame.
- R8: The byte on `txByte` is captured when the frame starts. Changes to `txByte` during the frame do not affect the bits sent.
- R9: Once the button has been released long enough to pass the debouncer, a new press sends a new frame with the byte present at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register uses its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| btnN | input | 1 | Raw push button, low while pressed |
| txByte | input | DATA_BITS | Byte to be sent, captured at frame start |
| txLine | output | 1 | Serial output, idles high |
| txActive | output | 1 | High while a frame is on the line |
| txDone | output | 1 | One-clock pulse after the stop bit ends |

## Verification
The bench builds the block with CLKS_PER_BIT of 8 and DEBOUNCE_CLKS of 4. With these values a whole frame takes 80 clocks, and the press-to-start-bit latency is a short count that can be checked to the exact edge. Hold times can then run well below and well above one frame time, and bounce pulses of three and two clocks fall just under the filter threshold. The bench decodes frames from the line by sampling at mid-bit. It checks that each press gives one frame and one completion pulse, and that glitches and byte changes during a frame have no effect.

// File: rtl/btn_uart_pkg.sv
package btn_uart_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_CLEANUP
  } txState_e;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA
  } lineSel_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic     load;
    logic     shift;
    logic     baudClr;
    lineSel_e lineSel;
  } txCtrl_t;

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int DEBOUNCE_CLKS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic btnN,
  output logic pressReq
);
  localparam int CW = $clog2(DEBOUNCE_CLKS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CLKS - 1);

  logic syncA, syncB;
  logic syncReq;
  logic [CW-1:0] holdCnt;

  // two-stage synchronizer, resets to "released"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= btnN;
      syncB <= syncA;
    end
  end

  assign syncReq = ~syncB;

  // new level must persist DEBOUNCE_CLKS clocks before it is accepted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= '0;
      pressReq <= 1'b0;
    end else if (syncReq == pressReq) begin
      holdCnt <= '0;
    end else if (holdCnt == CNT_LAST) begin
      holdCnt  <= '0;
      pressReq <= syncReq;
    end else begin
      holdCnt <= holdCnt + CW'(1);
    end
  end

  // R4: the filtered request only moves toward the synchronized level
  a_r4_follows_sync: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pressReq) |-> pressReq == $past(syncReq));

endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import btn_uart_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txCtrl_t              ctrl,
  input  logic [DATA_BITS-1:0] dataIn,
  output logic                 baudTick,
  output logic                 lastBit,
  output logic                 txLine
);
  localparam int BW = $clog2(CLKS_PER_BIT);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [BW-1:0] BAUD_LAST = BW'(CLKS_PER_BIT - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

  logic [BW-1:0]        baudCnt;
  logic [IW-1:0]        bitIdx;
  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baudCnt <= '0;
    end else if (ctrl.baudClr || baudCnt == BAUD_LAST) begin
      baudCnt <= '0;
    end else begin
      baudCnt <= baudCnt + BW'(1);
    end
  end

  assign baudTick = !ctrl.baudClr && (baudCnt == BAUD_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitIdx   <= '0;
    end else if (ctrl.load) begin
      shiftReg <= dataIn;
      bitIdx   <= '0;
    end else if (ctrl.shift) begin
      shiftReg <= shiftReg >> 1;
      bitIdx   <= bitIdx + IW'(1);
    end
  end

  assign lastBit = (bitIdx == IDX_LAST);

  always_comb begin
    case (ctrl.lineSel)
      LINE_SPACE: txLine = 1'b0;
      LINE_DATA:  txLine = shiftReg[0];
      default:    txLine = 1'b1;
    endcase
  end

  // R8: the shift register is only reloaded on a frame-start strobe
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ctrl.load) && !$past(ctrl.shift)) |-> $stable(shiftReg));

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import btn_uart_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pressReq,
  input  logic    baudTick,
  input  logic    lastBit,
  output txCtrl_t ctrl,
  output logic    txActive,
  output logic    txDone
);
  txState_e state, stateNext;

  always_comb begin
    stateNext    = state;
    ctrl.load    = 1'b0;
    ctrl.shift   = 1'b0;
    ctrl.baudClr = 1'b0;
    ctrl.lineSel = LINE_MARK;
    case (state)
      ST_IDLE: begin
        ctrl.baudClr = 1'b1;
        if (pressReq) begin
          ctrl.load = 1'b1;
          stateNext = ST_START;
        end
      end
      ST_START: begin
        ctrl.lineSel = LINE_SPACE;
        if (baudTick) stateNext = ST_DATA;
      end
      ST_DATA: begin
        ctrl.lineSel = LINE_DATA;
        if (baudTick) begin
          ctrl.shift = 1'b1;
          if (lastBit) stateNext = ST_STOP;
        end
      end
      ST_STOP: begin
        if (baudTick) stateNext = ST_CLEANUP;
      end
      ST_CLEANUP: begin
        ctrl.baudClr = 1'b1;
        if (!pressReq) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      txDone <= 1'b0;
    end else begin
      state  <= stateNext;
      txDone <= (state == ST_STOP) && baudTick;
    end
  end

  assign txActive = (state == ST_START) || (state == ST_DATA) || (state == ST_STOP);

  // R5: a held request keeps the machine parked after the frame
  a_r5_park_while_held: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CLEANUP && pressReq) |=> state == ST_CLEANUP);

  // R7: completion pulse lasts one clock
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  // R7: completion only follows the stop bit
  a_r7_done_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> $past(state) == ST_STOP);

endmodule

// File: rtl/btn_uart_tx.sv
module btn_uart_tx #(
  parameter int CLKS_PER_BIT  = 434,
  parameter int DEBOUNCE_CLKS = 50000,
  parameter int DATA_BITS     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 btnN,
  input  logic [DATA_BITS-1:0] txByte,
  output logic                 txLine,
  output logic                 txActive,
  output logic                 txDone
);
  import btn_uart_pkg::*;

  logic    pressReq;
  logic    baudTick;
  logic    lastBit;
  txCtrl_t ctrl;

  btn_conditioner #(.DEBOUNCE_CLKS(DEBOUNCE_CLKS)) cond_i (
    .clk      (clk),
    .rstN     (rstN),
    .btnN     (btnN),
    .pressReq (pressReq)
  );

  uart_tx_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pressReq (pressReq),
    .baudTick (baudTick),
    .lastBit  (lastBit),
    .ctrl     (ctrl),
    .txActive (txActive),
    .txDone   (txDone)
  );

  uart_tx_datapath #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .DATA_BITS    (DATA_BITS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .dataIn   (txByte),
    .baudTick (baudTick),
    .lastBit  (lastBit),
    .txLine   (txLine)
  );

  // R2: a frame opens with the start bit on the line
  a_r2_start_space: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> !txLine);

  // R6: busy drops together with the completion pulse
  a_r6_active_ends_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txActive) |-> txDone);

  // R1: line is high whenever no frame is running
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |-> txLine);

endmodule

// File: tb/btn_uart_tx_tb_top.sv
module btn_uart_tx_tb_top;
  localparam int CPB = 8;
  localparam int DEB = 4;
  localparam int NVEC = 6;
  // {byte[23:16], hold clocks[15:0]}
  localparam logic [23:0] VECS [NVEC] = '{
    24'hA5_000A, 24'h01_001E, 24'h80_0078,
    24'h5A_012C, 24'hFF_0006, 24'h00_00C8
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic btnN = 1'b1;
  logic [7:0] txByte = 8'h00;
  logic txLine, txActive, txDone;

  int tests = 0;
  int fails = 0;
  int frameCnt = 0;
  int doneCnt = 0;
  int doneDouble = 0;
  bit prevActive = 1'b0;
  bit prevDone = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  btn_uart_tx #(.CLKS_PER_BIT(CPB), .DEBOUNCE_CLKS(DEB), .DATA_BITS(8)) dut_i (
    .clk(clk), .rstN(rstN), .btnN(btnN), .txByte(txByte),
    .txLine(txLine), .txActive(txActive), .txDone(txDone)
  );

  always @(negedge clk) begin
    if (txActive && !prevActive) frameCnt++;
    if (txDone) doneCnt++;
    if (txDone && prevDone) doneDouble++;
    prevActive = txActive;
    prevDone = txDone;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // decode one frame at mid-bit; optionally alter txByte after the start bit
  task automatic rxFrame(output logic [7:0] got, output bit framingOk, input bit changeByte);
    int t = 0;
    framingOk = 1'b1;
    got = 8'h00;
    while (txLine && t < 1000) begin
      @(negedge clk);
      t++;
    end
    if (changeByte) txByte = ~txByte;
    waitClks(CPB / 2);
    if (txLine !== 1'b0 || txActive !== 1'b1) framingOk = 1'b0;
    for (int b = 0; b < 8; b++) begin
      waitClks(CPB);
      got[b] = txLine;
    end
    waitClks(CPB);
    if (txLine !== 1'b1 || txActive !== 1'b1) framingOk = 1'b0;
  endtask

  task automatic holdButton(input int n);
    btnN = 1'b0;
    waitClks(n);
    btnN = 1'b1;
  endtask

  initial begin
    logic [7:0] got;
    bit fok;
    int f0, d0, lat;

    waitClks(3);
    // R1: reset state
    chk(txLine === 1'b1, "R1 reset line", txLine, 1);
    chk(txActive === 1'b0, "R1 reset active", txActive, 0);
    chk(txDone === 1'b0, "R1 reset done", txDone, 0);
    rstN = 1'b1;
    waitClks(5);
    chk(txLine === 1'b1 && txActive === 1'b0, "R1 idle after reset", txLine, 1);

    // vector table: R2 R5 R6 R7 R9
    for (int v = 0; v < NVEC; v++) begin
      f0 = frameCnt;
      d0 = doneCnt;
      txByte = VECS[v][23:16];
      fork
        rxFrame(got, fok, 1'b0);
        holdButton(int'(VECS[v][15:0]));
      join
      waitClks(DEB + 10);
      chk(got == VECS[v][23:16], "R2 R9 byte", got, VECS[v][23:16]);
      chk(fok, "R2 R6 framing", fok, 1);
      chk(frameCnt - f0 == 1, "R5 one frame per press", frameCnt - f0, 1);
      chk(doneCnt - d0 == 1, "R7 one done per frame", doneCnt - d0, 1);
      chk(txLine === 1'b1 && txActive === 1'b0, "R1 idle between", txLine, 1);
    end
    chk(doneDouble == 0, "R7 done width", doneDouble, 0);

    // R3: exact press-to-start latency
    txByte = 8'h33;
    btnN = 1'b0;
    lat = 0;
    while (txLine && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == DEB + 3, "R3 latency", lat, DEB + 3);
    waitClks(12 * CPB);
    btnN = 1'b1;
    waitClks(DEB + 10);

    // R4: short low glitch sends nothing
    f0 = frameCnt;
    holdButton(DEB - 1);
    waitClks(15 * CPB);
    chk(frameCnt == f0, "R4 glitch ignored", frameCnt - f0, 0);
    chk(txLine === 1'b1, "R4 line stays high", txLine, 1);

    // R4 R5: bounce high while held after a frame is not a release
    f0 = frameCnt;
    txByte = 8'hC3;
    btnN = 1'b0;
    waitClks(12 * CPB);
    btnN = 1'b1;
    waitClks(2);
    btnN = 1'b0;
    waitClks(15 * CPB);
    chk(frameCnt - f0 == 1, "R4 R5 release bounce", frameCnt - f0, 1);
    chk(txActive === 1'b0 && txLine === 1'b1, "R6 parked quiet", txActive, 0);
    btnN = 1'b1;
    waitClks(DEB + 10);

    // R8: byte change during frame ignored
    txByte = 8'h3C;
    fork
      rxFrame(got, fok, 1'b1);
      holdButton(20);
    join
    waitClks(DEB + 10);
    chk(got == 8'h3C, "R8 latched byte", got, 8'h3C);
    chk(fok, "R8 framing", fok, 1);

    // R9: next press after release sends the new byte
    txByte = 8'h96;
    fork
      rxFrame(got, fok, 1'b0);
      holdButton(40);
    join
    waitClks(DEB + 10);
    chk(got == 8'h96, "R9 repress", got, 8'h96);
    chk(doneDouble == 0, "R7 done width end", doneDouble, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule